// File: doc/BRIEF.md
# Triggered Pixel-Group Hit Buffer

This block sits beside a small group of pixels and holds their hits until the level-1 trigger decision is known. On every clock cycle in which at least one active hit line of the group is high, the block builds an address word from the hit lines and takes the current bunch-crossing time stamp. It writes both into the lowest-indexed free cell of a pool of four identical cells.

Each occupied cell waits until the programmed latency has elapsed since its own time stamp. In that cycle the cell samples the trigger strobe. If the strobe is high, the cell is kept for readout. If it is low, the cell is freed. Kept cells leave one at a time through a valid/ready port, lowest index first.

A mode input selects between 8 and 16 pixels per group. A saturating counter records hits that found every cell occupied.

Each cell runs a three-state machine:
- EMPTY goes to WAIT on the transition *capture*.
- WAIT goes to READY on the transition *confirm*, when the latency has expired and the trigger is high.
- WAIT goes to EMPTY on the transition *discard*, when the latency has expired and the trigger is low.
- READY goes to EMPTY on the transition *drain*, when the cell's word is accepted.

Top module: `pixgrp_hitbuf`

## Requirements
- R1: After reset all cells are EMPTY, `rd_valid_o` is low and `drop_cnt_o` is zero.
- R2: In a cycle with an active hit, the lowest-indexed EMPTY cell captures the address word and the `bx_ts_i` value of that same cycle. The captured stamp appears on `rd_ts_o` when that cell is read.
- R3: With `grp16_i` low, address bit i (0..7) equals hit line i, bit 8 is 0, and lines 15..8 are ignored.
- R4: With `grp16_i` high, address bit i (0..7) is hit line i OR hit line i+8, and bit 8 (half-select) is the OR of lines 15..8.
- R5: A WAIT cell expires in the cycle where (`bx_ts_i` − stored stamp) mod 1024 equals `latency_i` (allowed range 1..1023). If `l1_trig_i` is high in that cycle, the cell becomes READY.
- R6: If `l1_trig_i` is low in the expiry cycle, the cell becomes EMPTY and its hit never appears at the output. A trigger in any other cycle has no effect on it.
- R7: `rd_valid_o` is high whenever any cell is READY. The word shown comes from the lowest-indexed READY cell. Once high, `rd_valid_o` stays high until a word is accepted.
- R8: The presented cell becomes EMPTY at the clock edge where `rd_valid_o` and `rd_ready_i` are both high.
- R9: A hit that finds no EMPTY cell is dropped and `drop_cnt_o` increments, saturating at 15.
- R10: Cells that expire in the same cycle are all decided by that cycle's single `l1_trig_i` sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_hit_i | input | 16 | Pixel hit lines |
| grp16_i | input | 1 | 1 = 16-pixel group, 0 = 8-pixel group |
| bx_ts_i | input | 10 | Free-running bunch-crossing time stamp |
| latency_i | input | 10 | Trigger latency in time-stamp counts |
| l1_trig_i | input | 1 | Level-1 trigger strobe |
| rd_valid_o | output | 1 | A confirmed hit is presented |
| rd_ready_i | input | 1 | Consumer accepts the presented hit |
| rd_addr_o | output | 9 | Address word; bit 8 is the half-select |
| rd_ts_o | output | 10 | Time stamp of the presented hit |
| drop_cnt_o | output | 4 | Saturating count of dropped hits |

## Verification
The hardest situation to reach is several cells expiring in the same cycle. That needs two cells holding identical stamps, which a time stamp advancing every cycle never produces. The bench therefore holds `bx_ts_i` still across two hit cycles and then sets the trigger both high and low at the shared expiry.

Saturating the drop counter needs all four cells pinned. For this the bench uses a long latency and sends a burst of hits with readout stalled.

A wrap of the stamp across 1023→0 and a long pseudo-random phase are both compared against a behavioural model on every cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        CELL_EMPTY = 2'd0,
        CELL_WAIT  = 2'd1,
        CELL_READY = 2'd2
    } cell_state_e;
endpackage

// File: rtl/hb_addr_map.sv
// Folds the pixel hit lines into one address word according to group size.
module hb_addr_map #(
    parameter int ADDR_W = 8
) (
    input  logic [2*ADDR_W-1:0] hits_i,
    input  logic                grp16_i,
    output logic [ADDR_W:0]     word_o,
    output logic                any_o
);
    logic [ADDR_W-1:0] upper_gated;

    assign upper_gated = hits_i[2*ADDR_W-1:ADDR_W] & {ADDR_W{grp16_i}};

    // Bit b is pixel b, plus pixel b+ADDR_W when the group is 16 wide.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign word_o[b] = hits_i[b] | upper_gated[b];
    end

    // Half-select bit: set when any upper-half pixel fired.
    assign word_o[ADDR_W] = |upper_gated;

    assign any_o = |word_o[ADDR_W-1:0];
endmodule

// File: rtl/hb_first_one.sv
// Lowest-index one-hot pick of a request vector.
module hb_first_one #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         found_o
);
    always_comb begin
        logic seen;
        seen    = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !seen) begin
                grant_o[i] = 1'b1;
                seen       = 1'b1;
            end
        end
    end

    assign found_o = |req_i;
endmodule

// File: rtl/hb_cell.sv
// One latency cell: EMPTY -capture-> WAIT -confirm-> READY -drain-> EMPTY,
//                   WAIT -discard-> EMPTY.
module hb_cell
    import hb_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int TS_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic [TS_W-1:0]   ts_now_i,
    input  logic [TS_W-1:0]   latency_i,
    input  logic              trig_i,
    input  logic              take_i,
    output logic              is_empty_o,
    output logic              is_ready_o,
    output logic [WORD_W-1:0] word_o,
    output logic [TS_W-1:0]   ts_o
);
    cell_state_e       st_q, st_d;
    logic [WORD_W-1:0] word_q;
    logic [TS_W-1:0]   ts_q;
    logic [TS_W-1:0]   age;
    logic              expired;

    // Age modulo 2**TS_W comes for free from the TS_W-wide subtraction.
    assign age     = ts_now_i - ts_q;
    assign expired = (age == latency_i);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CELL_EMPTY: if (wr_en_i) st_d = CELL_WAIT;   // capture
            CELL_WAIT: begin
                if (expired) begin
                    if (trig_i) st_d = CELL_READY;       // confirm
                    else        st_d = CELL_EMPTY;       // discard
                end
            end
            CELL_READY: if (take_i) st_d = CELL_EMPTY;   // drain
            default:    st_d = CELL_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CELL_EMPTY;
        else        st_q <= st_d;
    end

    // Payload register, loaded on capture only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ts_q   <= '0;
        end else if (st_q == CELL_EMPTY && wr_en_i) begin
            word_q <= wr_word_i;
            ts_q   <= ts_now_i;
        end
    end

    // Outputs
    always_comb begin
        is_empty_o = (st_q == CELL_EMPTY);
        is_ready_o = (st_q == CELL_READY);
        word_o     = word_q;
        ts_o       = ts_q;
    end

    AST_READY_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CELL_READY && $past(st_q) != CELL_READY) |-> $past(trig_i)); // R5

    AST_WAIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CELL_WAIT && $past(st_q) == CELL_EMPTY) |-> $past(wr_en_i)); // R2
endmodule

// File: rtl/pixgrp_hitbuf.sv
module pixgrp_hitbuf #(
    parameter int NCELLS = 4,
    parameter int ADDR_W = 8,
    parameter int TS_W   = 10,
    parameter int OVF_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*ADDR_W-1:0] pix_hit_i,
    input  logic                grp16_i,
    input  logic [TS_W-1:0]     bx_ts_i,
    input  logic [TS_W-1:0]     latency_i,
    input  logic                l1_trig_i,
    output logic                rd_valid_o,
    input  logic                rd_ready_i,
    output logic [ADDR_W:0]     rd_addr_o,
    output logic [TS_W-1:0]     rd_ts_o,
    output logic [OVF_W-1:0]    drop_cnt_o
);
    localparam int WORD_W = ADDR_W + 1;
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    logic [WORD_W-1:0] hit_word;
    logic              hit_any;
    logic [NCELLS-1:0] empty_v, ready_v, alloc_g, rd_g, wr_v, take_v;
    logic              have_empty, have_ready;
    logic [WORD_W-1:0] c_word [NCELLS];
    logic [TS_W-1:0]   c_ts   [NCELLS];
    logic [OVF_W-1:0]  drop_q;

    hb_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .hits_i (pix_hit_i),
        .grp16_i(grp16_i),
        .word_o (hit_word),
        .any_o  (hit_any)
    );

    hb_first_one #(.N(NCELLS)) u_alloc (
        .req_i  (empty_v),
        .grant_o(alloc_g),
        .found_o(have_empty)
    );

    hb_first_one #(.N(NCELLS)) u_rdsel (
        .req_i  (ready_v),
        .grant_o(rd_g),
        .found_o(have_ready)
    );

    assign wr_v   = alloc_g & {NCELLS{hit_any}};
    assign take_v = rd_g & {NCELLS{rd_ready_i}};

    for (genvar c = 0; c < NCELLS; c++) begin : g_cell
        hb_cell #(.WORD_W(WORD_W), .TS_W(TS_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_v[c]),
            .wr_word_i (hit_word),
            .ts_now_i  (bx_ts_i),
            .latency_i (latency_i),
            .trig_i    (l1_trig_i),
            .take_i    (take_v[c]),
            .is_empty_o(empty_v[c]),
            .is_ready_o(ready_v[c]),
            .word_o    (c_word[c]),
            .ts_o      (c_ts[c])
        );
    end

    // Read mux: OR of the one-hot selected cell
    always_comb begin
        rd_addr_o = '0;
        rd_ts_o   = '0;
        for (int i = 0; i < NCELLS; i++) begin
            if (rd_g[i]) begin
                rd_addr_o = rd_addr_o | c_word[i];
                rd_ts_o   = rd_ts_o | c_ts[i];
            end
        end
    end

    assign rd_valid_o = have_ready;

    // Drop counter, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drop_q <= '0;
        else if (hit_any && !have_empty && drop_q != OVF_MAX) drop_q <= drop_q + 1'b1;
    end

    assign drop_cnt_o = drop_q;

    AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_v)); // R2

    AST_DRAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_v)); // R8

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> rd_valid_o); // R7

    AST_NO_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q == OVF_MAX) |=> (drop_q == OVF_MAX)); // R9

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q != $past(drop_q)) |-> ($past(hit_any) && $past(empty_v) == '0)); // R9
endmodule

// File: tb/pixgrp_hitbuf_test.sv
module pixgrp_hitbuf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_hit = '0;
    logic        grp16 = 1'b0;
    logic [9:0]  ts = '0;
    logic [9:0]  lat = 10'd4;
    logic        trig = 1'b0;
    logic        rdy = 1'b0;
    logic        vld;
    logic [8:0]  raddr;
    logic [9:0]  rts;
    logic [3:0]  dcnt;

    int errors = 0;
    int checks = 0;
    logic [9:0] ts_r = 10'd100;

    // reference model: 0 empty, 1 waiting, 2 kept
    int mst [4];
    int mword [4];
    int mts [4];
    int mdrop;

    pixgrp_hitbuf uut (
        .clk(clk), .rst_n(rst_n), .pix_hit_i(pix_hit), .grp16_i(grp16),
        .bx_ts_i(ts), .latency_i(lat), .l1_trig_i(trig), .rd_valid_o(vld),
        .rd_ready_i(rdy), .rd_addr_o(raddr), .rd_ts_o(rts), .drop_cnt_o(dcnt)
    );

    always #5 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int model_word(input logic [15:0] h, input logic m16);
        int w;
        w = int'(h[7:0]);
        if (m16) begin
            w = w | int'(h[15:8]);
            if (h[15:8] != 8'd0) w = w | 256;
        end
        return w;
    endfunction

    // one clock: drive, compare, advance model
    task automatic cyc(input logic [15:0] h, input logic tg, input logic rd, input bit adv);
        int sel, nw, fe;
        bit taken;
        pix_hit = h; trig = tg; rdy = rd; ts = ts_r;
        #1;
        sel = -1;
        for (int c = 3; c >= 0; c--) if (mst[c] == 2) sel = c;
        chk(int'(vld), (sel >= 0) ? 1 : 0, "R7 valid");
        if (sel >= 0) begin
            chk(int'(raddr), mword[sel], grp16 ? "R4 addr" : "R3 addr");
            chk(int'(rts), mts[sel], "R2 stamp");
        end
        chk(int'(dcnt), mdrop, "R9 drop count");
        nw = model_word(h, grp16);
        fe = -1;
        for (int c = 3; c >= 0; c--) if (mst[c] == 0) fe = c;
        taken = (sel >= 0) && rd;
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            if (mst[c] == 1 && ((int'(ts_r) - mts[c]) & 1023) == int'(lat))
                mst[c] = tg ? 2 : 0;
        end
        if (taken) mst[sel] = 0;
        if ((nw & 255) != 0) begin
            if (fe >= 0) begin
                mst[fe] = 1; mword[fe] = nw; mts[fe] = int'(ts_r);
            end else if (mdrop < 15) mdrop++;
        end
        if (adv) ts_r = ts_r + 10'd1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(16'h0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        for (int c = 0; c < 4; c++) begin mst[c] = 0; mword[c] = 0; mts[c] = 0; end
        mdrop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(int'(vld), 0, "R1 valid after reset");
        chk(int'(dcnt), 0, "R1 drop count after reset");

        // R5: confirm at expiry, then drain (R8)
        cyc(16'h0005, 1'b0, 1'b0, 1'b1);
        idle(3);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(vld), 1, "R5 kept after trigger at expiry");
        chk(int'(raddr), 9'h005, "R3 eight-pixel word");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);
        chk(int'(vld), 0, "R8 freed on accept");

        // R6: trigger only off the expiry cycle -> discarded
        cyc(16'h0010, 1'b0, 1'b0, 1'b1);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        cyc(16'h0, 1'b0, 1'b0, 1'b1);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(vld), 0, "R6 discarded without trigger");

        // R4: sixteen-pixel mode, pixel 12 -> bit 4 plus half-select
        grp16 = 1'b1;
        cyc(16'h1000, 1'b0, 1'b0, 1'b1);
        idle(3);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(raddr), 9'h110, "R4 half-select word");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);

        // R3: eight-pixel mode ignores upper lines
        grp16 = 1'b0;
        cyc(16'hFF01, 1'b0, 1'b0, 1'b1);
        cyc(16'hFF00, 1'b0, 1'b0, 1'b1);
        idle(2);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(raddr), 9'h001, "R3 upper lines ignored");
        idle(1);
        chk(int'(vld), 1, "R3 only one hit stored");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);
        chk(int'(vld), 0, "R3 upper-only hit made no cell");

        // R10: two cells share a stamp, both kept by one trigger
        cyc(16'h0001, 1'b0, 1'b0, 1'b0);
        cyc(16'h0002, 1'b0, 1'b0, 1'b1);
        idle(3);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(raddr), 9'h001, "R10 first kept cell lowest index");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);
        chk(int'(vld), 1, "R10 second cell also kept");
        chk(int'(raddr), 9'h002, "R10 second kept word");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);
        // both discarded by one low sample
        cyc(16'h0004, 1'b0, 1'b0, 1'b0);
        cyc(16'h0008, 1'b0, 1'b0, 1'b1);
        idle(3);
        cyc(16'h0, 1'b0, 1'b0, 1'b1);
        chk(int'(vld), 0, "R10 both discarded together");

        // R5 across the 1023 -> 0 wrap
        ts_r = 10'd1021; lat = 10'd6;
        cyc(16'h0080, 1'b0, 1'b0, 1'b1);
        idle(5);
        cyc(16'h0, 1'b1, 1'b0, 1'b1);
        chk(int'(vld), 1, "R5 expiry across wrap");
        chk(int'(rts), 1021, "R2 stamp across wrap");
        cyc(16'h0, 1'b0, 1'b1, 1'b1);

        // R9: fill all cells, then overflow past saturation
        lat = 10'd40;
        for (int i = 0; i < 24; i++) cyc(16'h0003, 1'b0, 1'b0, 1'b1);
        chk(int'(dcnt), 15, "R9 drop counter saturates");
        idle(30);

        // pseudo-random phase, compared every cycle
        lat = 10'd7; grp16 = 1'b1;
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i == 300) grp16 = 1'b0;
            cyc((lf[3:0] == 4'd0) ? lf : 16'h0, lf[5], lf[7] | lf[9], lf[11] | lf[2]);
        end
        finish_run();
    end
endmodule